// File: doc/BRIEF.md
# Four-Phase Accumulator Instruction Executor

This block executes a small set of 16-bit instructions for an 8-bit accumulator machine. It fetches words from an external program store addressed by a 21-bit program counter. It keeps a working register (W) and a 4-bit bank register. File operands are read from and written to an external byte-wide data store through a 12-bit address. Branches, calls, stacks, table access and interrupts are not part of it.

Every instruction cycle lasts exactly four clocks. The word is fetched in the first clock. The operand is read during the second and third clocks. Results are committed in the fourth clock. The two-word absolute move takes two instruction cycles: it reads its source in the first cycle and writes its destination in the second. An 8-bit file field is widened to 12 bits in one of two ways. Banked accesses prefix the bank register. Unbanked accesses map the field into the lowest or highest 128 bytes of the space, chosen by the field's top bit. The data store answers reads combinationally, and writes take effect on the clock edge that ends the fourth phase.

Top module: `acc_core_exec`

## Requirements
- R1: While reset is asserted and until the first clock edge after its release, prog_addr, w_out and bank_out are zero and dmem_we is low.
- R2: prog_addr advances by one on the edge that ends the first clock of every instruction cycle and holds otherwise. A two-word move (first word 1100 followed by a 12-bit source) spends two cycles and advances it by two; every other word takes one cycle.
- R3: Word 0x0E followed by k loads k into W on the edge that ends the fourth clock; W changes at no other edge.
- R4: Word 0x010 followed by k[3:0] loads k into the bank register on the fourth-clock edge.
- R5: Word 0110 111a followed by f writes W to the effective address. With a=1 the address is {bank,f}. With a=0 it is {0x0,f} when f[7]=0 and {0xF,f} when f[7]=1.
- R6: Word 0101 00da followed by f reads the effective address. d=0 places the value in W. d=1 writes the same value back to that address and leaves W unchanged.
- R7: Word 0010 01da followed by f computes (file + W) mod 256. d=0 puts it in W; d=1 puts it in the file location. The other operand is unchanged.
- R8: Word 0101 11da followed by f computes (file - W) mod 256, with the same destination rule as R7.
- R9: A first word 1100 followed by source s, then a second word 1111 followed by destination t, copies the byte at s to t. W and the bank register are unchanged.
- R10: Any other word is a one-cycle no-operation: no data write, and W and the bank register are unchanged.
- R11: dmem_we is high only during the fourth clock of a cycle, for exactly one clock per writing instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | 21 | Word address of the program store (the program counter) |
| prog_data | input | 16 | Instruction word at prog_addr |
| dmem_addr | output | 12 | Data store address |
| dmem_wdata | output | 8 | Data store write value |
| dmem_rdata | input | 8 | Data store read value at dmem_addr |
| dmem_we | output | 1 | Data store write strobe |
| w_out | output | 8 | Working register |
| bank_out | output | 4 | Bank register |

## Verification
W and bank results are due on the fourth rising edge after an instruction's fetch clock begins. Data writes land on that same edge. A two-word move delivers its copy on the eighth edge, and the program counter has advanced by the time the next fetch clock starts. The bench issues each instruction in the fetch clock and then waits exactly four or eight rising edges. It samples all results on the following falling edge. It also counts edges since reset, so that any write strobe outside the fourth clock of a cycle is detected.

// File: rtl/acc_pkg.sv
package acc_pkg;

   typedef enum logic [2:0] {
      OP_NOP,
      OP_LDW,
      OP_LDBANK,
      OP_STW,
      OP_COPYF,
      OP_ADDF,
      OP_SUBF,
      OP_MOVABS
   } op_e;

   typedef enum logic [1:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_SUB
   } alu_e;

   typedef struct packed {
      op_e         op;
      logic        dst_f;
      logic        banked;
      logic [7:0]  fld;
      logic [11:0] abs_adr;
   } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_pkg::*;
#(
   parameter int IW = 16
) (
   input  logic [IW-1:0] ir,
   output dec_t          dec
);

   always_comb begin
      dec.op      = OP_NOP;
      dec.dst_f   = ir[9];
      dec.banked  = ir[8];
      dec.fld     = ir[7:0];
      dec.abs_adr = ir[11:0];
      if (ir[15:8] == 8'h0E)
         dec.op = OP_LDW;
      else if (ir[15:4] == 12'h010)
         dec.op = OP_LDBANK;
      else if (ir[15:9] == 7'b0110111)
         dec.op = OP_STW;
      else if (ir[15:10] == 6'b010100)
         dec.op = OP_COPYF;
      else if (ir[15:10] == 6'b001001)
         dec.op = OP_ADDF;
      else if (ir[15:10] == 6'b010111)
         dec.op = OP_SUBF;
      else if (ir[15:12] == 4'hC)
         dec.op = OP_MOVABS;
   end

endmodule

// File: rtl/acc_bank_addr.sv
module acc_bank_addr #(
   parameter int DW     = 8,
   parameter int BANK_W = 4
) (
   input  logic [DW-1:0]        fld,
   input  logic                 banked,
   input  logic [BANK_W-1:0]    bank,
   output logic [BANK_W+DW-1:0] ea
);

   localparam logic [BANK_W-1:0] LOW_PAGE  = '0;
   localparam logic [BANK_W-1:0] HIGH_PAGE = '1;

   always_comb begin
      if (banked)
         ea = {bank, fld};
      else if (fld[DW-1])
         ea = {HIGH_PAGE, fld};
      else
         ea = {LOW_PAGE, fld};
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DW          = 8,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  alu_e          sel,
   input  logic [DW-1:0] f_val,
   input  logic [DW-1:0] w_val,
   output logic [DW-1:0] res
);

   logic [DW-1:0] diff;

   generate
      if (SUB_VIA_ADD) begin : g_sub_add
         always_comb diff = f_val + ~w_val + {{(DW-1){1'b0}}, 1'b1};
      end else begin : g_sub_direct
         always_comb diff = f_val - w_val;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         ALU_ADD: res = f_val + w_val;
         ALU_SUB: res = diff;
         default: res = f_val;
      endcase
   end

endmodule

// File: rtl/acc_core_exec.sv
module acc_core_exec
   import acc_pkg::*;
#(
   parameter int PC_W        = 21,
   parameter int DW          = 8,
   parameter int IW          = 16,
   parameter int BANK_W      = 4,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [PC_W-1:0]      prog_addr,
   input  logic [IW-1:0]        prog_data,
   output logic [BANK_W+DW-1:0] dmem_addr,
   output logic [DW-1:0]        dmem_wdata,
   input  logic [DW-1:0]        dmem_rdata,
   output logic                 dmem_we,
   output logic [DW-1:0]        w_out,
   output logic [BANK_W-1:0]    bank_out
);

   localparam int AW   = BANK_W + DW;
   localparam int PH_W = 2;
   localparam logic [PH_W-1:0] PH_FETCH = 2'd0;
   localparam logic [PH_W-1:0] PH_LATCH = 2'd2;
   localparam logic [PH_W-1:0] PH_WB    = 2'd3;
   localparam logic [PC_W-1:0] PC_STEP  = {{(PC_W-1){1'b0}}, 1'b1};

   generate
      if (IW != 16 || DW != 8 || BANK_W != 4) begin : g_bad_cfg
         $error("acc_core_exec: encoding needs IW=16, DW=8, BANK_W=4");
      end
      if (PC_W < 2) begin : g_bad_pc
         $error("acc_core_exec: PC_W too small");
      end
   endgenerate

   logic [PH_W-1:0]   ph;
   logic [PC_W-1:0]   pc;
   logic [IW-1:0]     ir;
   logic [DW-1:0]     wreg;
   logic [BANK_W-1:0] bank;
   logic [DW-1:0]     opnd;
   logic              ff_second;

   dec_t          dec;
   logic [AW-1:0] ea;
   alu_e          alu_sel;
   logic [DW-1:0] alu_res;
   logic          is_file_op;
   logic          wr_file;
   logic          wr_w;

   acc_decode #(.IW(IW)) u_dec (
      .ir  (ir),
      .dec (dec)
   );

   acc_bank_addr #(.DW(DW), .BANK_W(BANK_W)) u_bank (
      .fld    (dec.fld),
      .banked (dec.banked),
      .bank   (bank),
      .ea     (ea)
   );

   acc_alu #(.DW(DW), .SUB_VIA_ADD(SUB_VIA_ADD)) u_alu (
      .sel   (alu_sel),
      .f_val (opnd),
      .w_val (wreg),
      .res   (alu_res)
   );

   always_comb begin
      is_file_op = (dec.op == OP_COPYF) || (dec.op == OP_ADDF) || (dec.op == OP_SUBF);
      unique case (dec.op)
         OP_ADDF: alu_sel = ALU_ADD;
         OP_SUBF: alu_sel = ALU_SUB;
         default: alu_sel = ALU_PASS;
      endcase
      wr_file = ff_second || (dec.op == OP_STW) || (is_file_op && dec.dst_f);
      wr_w    = !ff_second && ((dec.op == OP_LDW) || (is_file_op && !dec.dst_f));
   end

   always_comb begin
      if (ff_second || dec.op == OP_MOVABS)
         dmem_addr = AW'(dec.abs_adr);
      else
         dmem_addr = ea;
      if (ff_second)
         dmem_wdata = opnd;
      else if (dec.op == OP_STW)
         dmem_wdata = wreg;
      else
         dmem_wdata = alu_res;
      dmem_we = (ph == PH_WB) && wr_file;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= '0;
         pc        <= '0;
         ir        <= '0;
         wreg      <= '0;
         bank      <= '0;
         opnd      <= '0;
         ff_second <= 1'b0;
      end else begin
         ph <= ph + 1'b1;
         if (ph == PH_FETCH) begin
            ir <= prog_data;
            pc <= pc + PC_STEP;
         end
         if (ph == PH_LATCH && !ff_second)
            opnd <= dmem_rdata;
         if (ph == PH_WB) begin
            if (wr_w)
               wreg <= (dec.op == OP_LDW) ? dec.fld : alu_res;
            if (!ff_second && dec.op == OP_LDBANK)
               bank <= dec.fld[BANK_W-1:0];
            ff_second <= !ff_second && (dec.op == OP_MOVABS);
         end
      end
   end

   assign prog_addr = pc;
   assign w_out     = wreg;
   assign bank_out  = bank;

endmodule

// File: rtl/acc_core_exec_chk.sv
module acc_core_exec_chk #(
   parameter int PC_W   = 21,
   parameter int DW     = 8,
   parameter int BANK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        ph,
   input logic              ff_second,
   input logic [PC_W-1:0]   prog_addr,
   input logic              dmem_we,
   input logic [DW-1:0]     w_out,
   input logic [BANK_W-1:0] bank_out
);

   localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

   AST_WE_FOURTH_PHASE: assert property (@(posedge clk) disable iff (!rst_n) dmem_we |-> ph == 2'd3); // R11
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) ph == 2'd0 |=> prog_addr == $past(prog_addr) + ONE); // R2
   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ph != 2'd0 |=> $stable(prog_addr)); // R2
   AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ph != 2'd3 |=> $stable(w_out)); // R3
   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ph != 2'd3 |=> $stable(bank_out)); // R4
   AST_MOVE_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_n) (ff_second && ph == 2'd3) |=> $stable(w_out)); // R9

endmodule

bind acc_core_exec acc_core_exec_chk #(.PC_W(PC_W), .DW(DW), .BANK_W(BANK_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ph        (ph),
   .ff_second (ff_second),
   .prog_addr (prog_addr),
   .dmem_we   (dmem_we),
   .w_out     (w_out),
   .bank_out  (bank_out)
);

// File: tb/tb_acc_core_exec.sv
`timescale 1ns/1ps
module tb_acc_core_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [20:0] prog_addr;
   logic [15:0] prog_data;
   logic [11:0] dmem_addr;
   logic [7:0]  dmem_wdata;
   logic [7:0]  dmem_rdata;
   logic        dmem_we;
   logic [7:0]  w_out;
   logic [3:0]  bank_out;

   logic [15:0] prog [0:255];
   logic [7:0]  mem [0:4095];
   logic [7:0]  exp_mem [0:4095];
   logic [7:0]  ref_w;
   logic [3:0]  ref_bank;
   logic [20:0] pc_ref;
   int          checks = 0;
   int          errors = 0;
   int          we_cnt = 0;
   int          edges = 0;
   int          misplaced = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   acc_core_exec dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .dmem_we    (dmem_we),
      .w_out      (w_out),
      .bank_out   (bank_out)
   );

   assign prog_data  = prog[prog_addr[7:0]];
   assign dmem_rdata = mem[dmem_addr];

   always @(posedge clk) begin
      if (rst_n) edges <= edges + 1;
      if (dmem_we) begin
         mem[dmem_addr] <= dmem_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   always @(negedge clk)
      if (rst_n && dmem_we && (edges % 4 != 3)) misplaced <= misplaced + 1;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] eff(input logic [7:0] f, input logic a);
      if (a) return {ref_bank, f};
      return f[7] ? {4'hF, f} : {4'h0, f};
   endfunction

   task automatic run(input logic [15:0] w1, input logic [15:0] w2, input string req);
      bit          two;
      bit          wr;
      logic [11:0] ta;
      logic [7:0]  v;
      int          we0;
      two = (w1[15:12] == 4'hC);
      wr  = 1'b0;
      ta  = 12'h020;
      if (w1[15:8] == 8'h0E) ref_w = w1[7:0];
      else if (w1[15:4] == 12'h010) ref_bank = w1[3:0];
      else if (w1[15:9] == 7'b0110111) begin
         ta = eff(w1[7:0], w1[8]); exp_mem[ta] = ref_w; wr = 1'b1;
      end else if (w1[15:10] == 6'b010100 || w1[15:10] == 6'b001001 || w1[15:10] == 6'b010111) begin
         ta = eff(w1[7:0], w1[8]);
         v = exp_mem[ta];
         if (w1[15:10] == 6'b001001) v = v + ref_w;
         if (w1[15:10] == 6'b010111) v = v - ref_w;
         if (w1[9]) begin exp_mem[ta] = v; wr = 1'b1; end
         else ref_w = v;
      end else if (two) begin
         ta = w2[11:0]; exp_mem[ta] = exp_mem[w1[11:0]]; wr = 1'b1;
      end
      prog[pc_ref[7:0]] = w1;
      if (two) prog[pc_ref[7:0] + 8'd1] = w2;
      we0 = we_cnt;
      repeat (two ? 8 : 4) @(posedge clk);
      @(negedge clk);
      pc_ref = pc_ref + (two ? 21'd2 : 21'd1);
      chk(req, "W", w_out, ref_w);
      chk(req, "bank", bank_out, ref_bank);
      chk(req, "pc (R2)", prog_addr, pc_ref);
      chk(req, "writes (R11)", we_cnt - we0, wr ? 1 : 0);
      chk(req, "mem", mem[ta], exp_mem[ta]);
   endtask

   function automatic logic [15:0] e_ldw(input logic [7:0] k);  return {8'h0E, k}; endfunction
   function automatic logic [15:0] e_stw(input logic [7:0] f, input logic a); return {7'b0110111, a, f}; endfunction
   function automatic logic [15:0] e_cpf(input logic [7:0] f, input logic d, input logic a); return {6'b010100, d, a, f}; endfunction
   function automatic logic [15:0] e_add(input logic [7:0] f, input logic d, input logic a); return {6'b001001, d, a, f}; endfunction
   function automatic logic [15:0] e_sub(input logic [7:0] f, input logic d, input logic a); return {6'b010111, d, a, f}; endfunction

   initial begin
      for (int i = 0; i < 4096; i++) begin mem[i] = '0; exp_mem[i] = '0; end
      for (int i = 0; i < 256; i++) prog[i] = '0;
      ref_w = '0; ref_bank = '0; pc_ref = '0;
      repeat (3) @(negedge clk);
      chk("R1", "pc in reset", prog_addr, 0);
      rst_n = 1'b1;
      chk("R1", "pc", prog_addr, 0);
      chk("R1", "W", w_out, 0);
      chk("R1", "bank", bank_out, 0);
      chk("R1", "we", dmem_we, 0);

      run(16'h0102, 16'h0, "R4");
      run(e_ldw(8'h5A), 16'h0, "R3");
      run(e_stw(8'h70, 1'b1), 16'h0, "R5 banked 0x270");
      run(e_stw(8'h70, 1'b0), 16'h0, "R5 low 0x070");
      run(e_stw(8'h90, 1'b0), 16'h0, "R5 high 0xF90");
      run(e_ldw(8'h00), 16'h0, "R3");
      run(e_cpf(8'h70, 1'b0, 1'b1), 16'h0, "R6 to W");
      run(e_ldw(8'h11), 16'h0, "R3");
      run(e_cpf(8'h90, 1'b1, 1'b0), 16'h0, "R6 write back");
      chk("R5", "mem 0x270", mem[12'h270], 8'h5A);
      chk("R5", "mem 0xF90", mem[12'hF90], 8'h5A);

      for (int i = 0; i < 7; i++) begin
         for (int j = 0; j < 7; j++) begin
            logic [7:0] a, b;
            a = 8'((i * 37 + 3) & 255);
            b = 8'((j * 41 + 1) & 255);
            run(e_ldw(a), 16'h0, "R3");
            run(e_stw(8'h20, 1'b0), 16'h0, "R5");
            run(e_ldw(b), 16'h0, "R3");
            run(e_add(8'h20, 1'b0, 1'b0), 16'h0, "R7 to W");
            chk("R7", "sum", w_out, 8'(a + b));
            run(e_ldw(b), 16'h0, "R3");
            run(e_add(8'h20, 1'b1, 1'b0), 16'h0, "R7 to file");
            run(e_sub(8'h20, 1'b0, 1'b0), 16'h0, "R8 to W");
            chk("R8", "diff", w_out, a);
            run(e_sub(8'h20, 1'b1, 1'b0), 16'h0, "R8 to file");
            chk("R8", "file diff", mem[12'h020], b);
         end
      end

      run(16'h0101, 16'h0, "R4");
      run(e_ldw(8'hC3), 16'h0, "R3");
      run(e_stw(8'hA0, 1'b1), 16'h0, "R5");
      run(e_ldw(8'h66), 16'h0, "R3");
      run(16'hC1A0, 16'hF23F, "R9");
      chk("R9", "copy 0x23F", mem[12'h23F], 8'hC3);
      run(16'hCF90, 16'hF005, "R9");
      chk("R9", "copy 0x005", mem[12'h005], 8'h5A);

      run(16'h0000, 16'h0, "R10");
      run(16'hFFFF, 16'h0, "R10");
      run(16'h0115, 16'h0, "R10");
      run(16'h3412, 16'h0, "R10");
      run(16'h0F00, 16'h0, "R10");

      chk("R11", "misplaced writes", misplaced, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule